// File: doc/BRIEF.md
# Byte-Wide EEPROM Page-Write Controller

This block is the write side of an emulated byte-wide EEPROM that runs on a synchronous system clock. It takes the asynchronous active-low chip-select, write-strobe and output-enable pins and an active-low protect/reset pin. Each pin is synchronised and glitch-filtered. Valid write strobes are collected into a page buffer of up to 64 bytes. When the strobes have been quiet for a set time, a timed internal program cycle starts. At the end of that cycle, the loaded bytes are committed to a behavioural memory array.

A byte is taken only while chip-select and write-strobe are both low, output-enable is high and the protect pin is high. Its offset within the page is sampled when the strobe becomes active, and its data when the strobe ends. The page number is fixed by the first byte of a load. Every later byte of that load must start within a load window measured from the previous byte's start. All intervals are parameters counted in clock ticks, so a simulation can shrink them. A registered read port exposes the array contents to the read side of the emulator. A busy flag reports that a load or program cycle is in progress. `addr` and `din` must be held stable across the input conditioning latency (two sync stages plus `FILT_CYCLES`) around each strobe edge.

Top module: `eeprom_page_writer`

## Requirements
- R1: After the synchronous reset `rst`, `busy` is low and no page load is in progress.
- R2: A byte is accepted only while `ce_n`=0, `we_n`=0, `oe_n`=1 and `res_n`=1. A strobe made with `oe_n`=0 stores nothing and leaves `busy` low.
- R3: A low pulse on the control pins that is shorter than `FILT_CYCLES` clock cycles (after two synchroniser stages) starts no write.
- R4: The byte offset (`addr` bits 5..0) is sampled when the strobe becomes active. The data is sampled when the strobe ends, so changes to `din` during the strobe take effect and changes to the offset do not.
- R5: The page number (`addr` bits above bit 5) is frozen at the first byte of a load. The page bits of every later byte in that load are ignored.
- R6: A byte whose strobe starts more than `WIN_TICKS` cycles after the previous accepted strobe start is ignored. The bytes loaded before it are still programmed.
- R7: The program cycle starts once the strobe has been inactive for `IDLE_TICKS` cycles after the last data byte. It writes only the loaded offsets of the page, and all other bytes of the page keep their previous value.
- R8: `busy` rises when the first byte's data is latched, not when its strobe begins. It stays high until the commit at the end of the program cycle finishes, about `IDLE_TICKS`+`PROG_TICKS`+64 cycles later.
- R9: Strobes that arrive while the program cycle is running are ignored.
- R10: Driving `res_n` low aborts a load or program cycle: `busy` drops, and a program cycle aborted before commit leaves the page unchanged. Strobes made while `res_n` is low are ignored.
- R11: One load can fill all 64 offsets of a page, and all of them are programmed in a single cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| res_n | input | 1 | Asynchronous active-low write protect / program abort |
| ce_n | input | 1 | Asynchronous active-low chip select |
| we_n | input | 1 | Asynchronous active-low write strobe |
| oe_n | input | 1 | Asynchronous active-low output enable |
| addr | input | ADDR_W | Byte address; bits 5..0 are the offset, the bits above are the page |
| din | input | 8 | Write data |
| rd_addr | input | ADDR_W | Read-side array address |
| rd_data | output | 8 | Registered array contents at `rd_addr` (one cycle latency) |
| busy | output | 1 | Load or program cycle in progress |

## Verification
Several strobe patterns are used, and each one separates a different failure:
- Short in-window bursts, a full 64-byte burst and a partial rewrite of an already programmed page check that only the loaded offsets change.
- A strobe during which both `din` and the offset change shows which edge samples each one.
- A later byte with different page bits shows whether the page is frozen.
- A late second byte, a too-short glitch and a strobe with output-enable low must all be rejected while the earlier bytes still land.
- Strobes during the program cycle, and a protect-pin pulse in the middle of the cycle, separate "ignored" and "aborted" from "queued" or "committed anyway".

// File: rtl/eepw_pkg.sv
package eepw_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_LOAD   = 2'd1,
    ST_PROG   = 2'd2,
    ST_COMMIT = 2'd3
  } state_t;

  // lane positions of the conditioned control pins
  localparam int CH_CE  = 0;
  localparam int CH_WE  = 1;
  localparam int CH_OE  = 2;
  localparam int CH_RES = 3;
  localparam int N_CH   = 4;

endpackage

// File: rtl/strobe_conditioner.sv
module strobe_conditioner #(
  parameter int N    = 4,
  parameter int FILT = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] raw,
  output logic [N-1:0] clean
);
  localparam int CW = $clog2(FILT + 1);

  for (genvar i = 0; i < N; i++) begin : g_lane
    logic          s1, s2, f;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
      if (rst) begin
        s1  <= 1'b1;
        s2  <= 1'b1;
        f   <= 1'b1;
        cnt <= '0;
      end else begin
        s1 <= raw[i];
        s2 <= s1;
        if (s2 == f) begin
          cnt <= '0;
        end else if (cnt == CW'(FILT - 1)) begin
          f   <= s2;
          cnt <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end

    assign clean[i] = f;
  end

endmodule

// File: rtl/page_buffer.sv
module page_buffer #(
  parameter int BYTES = 64,
  parameter int DW    = 8,
  localparam int OW   = $clog2(BYTES)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          wr_en,
  input  logic [OW-1:0] wr_off,
  input  logic [DW-1:0] wr_data,
  input  logic [OW-1:0] rd_off,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid
);
  logic [DW-1:0]    data_q [BYTES];
  logic [BYTES-1:0] valid_q;

  always_ff @(posedge clk) begin
    if (wr_en) data_q[wr_off] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst || clr)  valid_q <= '0;
    else if (wr_en)  valid_q[wr_off] <= 1'b1;
  end

  assign rd_data  = data_q[rd_off];
  assign rd_valid = valid_q[rd_off];

endmodule

// File: rtl/eep_array.sv
module eep_array #(
  parameter int AW = 11,
  parameter int DW = 8,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/eeprom_page_writer.sv
module eeprom_page_writer
  import eepw_pkg::*;
#(
  parameter int ADDR_W      = 11,
  parameter int PAGE_BYTES  = 64,
  parameter int FILT_CYCLES = 3,
  parameter int WIN_TICKS   = 3750,
  parameter int IDLE_TICKS  = 12500,
  parameter int PROG_TICKS  = 1250000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              res_n,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        din,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data,
  output logic              busy
);
  localparam int OFF_W  = $clog2(PAGE_BYTES);
  localparam int PG_W   = ADDR_W - OFF_W;
  localparam int WIN_W  = $clog2(WIN_TICKS + 1);
  localparam int IDLE_W = $clog2(IDLE_TICKS + 1);
  localparam int PROG_W = $clog2(PROG_TICKS + 1);

  logic [N_CH-1:0] raw, clean;
  assign raw[CH_CE]  = ce_n;
  assign raw[CH_WE]  = we_n;
  assign raw[CH_OE]  = oe_n;
  assign raw[CH_RES] = res_n;

  strobe_conditioner #(.N(N_CH), .FILT(FILT_CYCLES)) i_cond (
    .clk(clk), .rst(rst), .raw(raw), .clean(clean)
  );

  logic res_f, act, act_q, go, fin;
  assign res_f = clean[CH_RES];
  assign act   = !clean[CH_CE] && !clean[CH_WE] && clean[CH_OE] && res_f;
  assign go    = act && !act_q;
  assign fin   = !act && act_q;

  state_t            state;
  logic [PG_W-1:0]   page_q;
  logic [OFF_W-1:0]  off_q, sweep;
  logic              in_byte;
  logic [WIN_W-1:0]  win_cnt;
  logic [IDLE_W-1:0] idle_cnt;
  logic [PROG_W-1:0] prog_cnt;
  logic              win_open, sweep_last;

  assign win_open   = win_cnt < WIN_W'(WIN_TICKS);
  assign sweep_last = sweep == OFF_W'(PAGE_BYTES - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      act_q    <= 1'b0;
      busy     <= 1'b0;
      in_byte  <= 1'b0;
      page_q   <= '0;
      off_q    <= '0;
      sweep    <= '0;
      win_cnt  <= '0;
      idle_cnt <= '0;
      prog_cnt <= '0;
    end else begin
      act_q <= act;
      if (!res_f) begin
        state   <= ST_IDLE;
        busy    <= 1'b0;
        in_byte <= 1'b0;
      end else begin
        unique case (state)
          ST_IDLE: if (go) begin
            page_q   <= addr[ADDR_W-1:OFF_W];
            off_q    <= addr[OFF_W-1:0];
            in_byte  <= 1'b1;
            win_cnt  <= '0;
            idle_cnt <= '0;
            state    <= ST_LOAD;
          end
          ST_LOAD: begin
            if (win_open) win_cnt <= win_cnt + 1'b1;
            if (go && win_open && !in_byte) begin
              off_q    <= addr[OFF_W-1:0];
              in_byte  <= 1'b1;
              win_cnt  <= '0;
              idle_cnt <= '0;
            end else if (fin && in_byte) begin
              in_byte  <= 1'b0;
              busy     <= 1'b1;
              idle_cnt <= '0;
            end else if (!in_byte) begin
              if (idle_cnt == IDLE_W'(IDLE_TICKS - 1)) begin
                state    <= ST_PROG;
                prog_cnt <= '0;
              end else begin
                idle_cnt <= idle_cnt + 1'b1;
              end
            end
          end
          ST_PROG: begin
            if (prog_cnt == PROG_W'(PROG_TICKS - 1)) begin
              state <= ST_COMMIT;
              sweep <= '0;
            end else begin
              prog_cnt <= prog_cnt + 1'b1;
            end
          end
          ST_COMMIT: begin
            if (sweep_last) begin
              state <= ST_IDLE;
              busy  <= 1'b0;
            end else begin
              sweep <= sweep + 1'b1;
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  logic       buf_we, buf_clr, buf_valid, arr_we;
  logic [7:0] buf_data;

  assign buf_we  = res_f && (state == ST_LOAD) && fin && in_byte;
  assign buf_clr = !res_f || ((state == ST_COMMIT) && sweep_last);

  page_buffer #(.BYTES(PAGE_BYTES), .DW(8)) i_buf (
    .clk(clk), .rst(rst), .clr(buf_clr),
    .wr_en(buf_we), .wr_off(off_q), .wr_data(din),
    .rd_off(sweep), .rd_data(buf_data), .rd_valid(buf_valid)
  );

  assign arr_we = res_f && (state == ST_COMMIT) && buf_valid;

  eep_array #(.AW(ADDR_W), .DW(8)) i_arr (
    .clk(clk), .we(arr_we), .waddr({page_q, sweep}), .wdata(buf_data),
    .raddr(rd_addr), .rdata(rd_data)
  );

endmodule

// File: rtl/eepw_checker.sv
module eepw_checker
  import eepw_pkg::*;
#(
  parameter int PG_W = 5
) (
  input logic            clk,
  input logic            rst,
  input logic            res_f,
  input logic            busy,
  input state_t          state,
  input logic [PG_W-1:0] page_q,
  input logic            arr_we
);
  p_page_frozen_r5: assert property (@(posedge clk) disable iff (rst)
    (state == ST_LOAD && $past(state) == ST_LOAD) |-> $stable(page_q));

  p_commit_only_r7: assert property (@(posedge clk) disable iff (rst)
    arr_we |-> (state == ST_COMMIT && busy));

  p_prog_busy_r8: assert property (@(posedge clk) disable iff (rst)
    (state == ST_PROG) |-> busy);

  p_prog_no_reload_r9: assert property (@(posedge clk) disable iff (rst)
    (state == ST_PROG) |=> (state != ST_LOAD));

  p_abort_clears_r10: assert property (@(posedge clk) disable iff (rst)
    !res_f |=> !busy);
endmodule

bind eeprom_page_writer eepw_checker #(.PG_W(PG_W)) i_chk (
  .clk(clk), .rst(rst), .res_f(res_f), .busy(busy),
  .state(state), .page_q(page_q), .arr_we(arr_we)
);

// File: tb/test_eeprom_page_writer.sv
module test_eeprom_page_writer;
  localparam int AW   = 11;
  localparam int FILT = 3;
  localparam int WIN  = 40;
  localparam int IDLE = 100;
  localparam int PROG = 200;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          res_n = 1'b1, ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [AW-1:0] addr = '0, rd_addr = '0;
  logic [7:0]    din = '0;
  logic [7:0]    rd_data;
  logic          busy;
  int            n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  eeprom_page_writer #(
    .ADDR_W(AW), .PAGE_BYTES(64), .FILT_CYCLES(FILT),
    .WIN_TICKS(WIN), .IDLE_TICKS(IDLE), .PROG_TICKS(PROG)
  ) i_eeprom_page_writer (
    .clk(clk), .rst(rst), .res_n(res_n), .ce_n(ce_n), .we_n(we_n),
    .oe_n(oe_n), .addr(addr), .din(din), .rd_addr(rd_addr),
    .rd_data(rd_data), .busy(busy)
  );

  function automatic logic [AW-1:0] mk(input int pg, input int off);
    return AW'((pg << 6) | (off & 63));
  endfunction

  task automatic check(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic strobe(input logic [AW-1:0] a, input logic [7:0] d, input bit oe_low);
    addr = a; din = d; oe_n = !oe_low;
    cyc(1);
    ce_n = 1'b0; we_n = 1'b0;
    cyc(8);
    ce_n = 1'b1; we_n = 1'b1;
    cyc(8);
    oe_n = 1'b1;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [7:0] v);
    rd_addr = a;
    cyc(2);
    v = rd_data;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 3000 && busy; i++) cyc(1);
  endtask

  task automatic t_reset();
    check(busy === 1'b0, "R1 busy after reset", {7'd0, busy}, 8'd0);
  endtask

  task automatic t_basic();
    logic [7:0] v;
    addr = mk(3, 0); din = 8'h10;
    cyc(1); ce_n = 0; we_n = 0; cyc(8);
    check(busy === 1'b0, "R8 busy low before data latch", {7'd0, busy}, 8'd0);
    ce_n = 1; we_n = 1; cyc(8);
    check(busy === 1'b1, "R8 busy high after first latch", {7'd0, busy}, 8'd1);
    for (int k = 1; k < 4; k++) strobe(mk(3, k), 8'h10 + 8'(k), 0);
    cyc(IDLE - 30);
    check(busy === 1'b1, "R7 busy held through idle wait", {7'd0, busy}, 8'd1);
    wait_idle();
    check(busy === 1'b0, "R8 busy falls after commit", {7'd0, busy}, 8'd0);
    for (int k = 0; k < 4; k++) begin
      rd(mk(3, k), v);
      check(v === 8'h10 + 8'(k), "R7 page bytes programmed", v, 8'h10 + 8'(k));
    end
  endtask

  task automatic t_partial();
    logic [7:0] v;
    strobe(mk(3, 1), 8'hB1, 0);
    strobe(mk(3, 2), 8'hB2, 0);
    wait_idle();
    rd(mk(3, 0), v); check(v === 8'h10, "R7 unloaded byte 0 kept", v, 8'h10);
    rd(mk(3, 1), v); check(v === 8'hB1, "R7 loaded byte 1", v, 8'hB1);
    rd(mk(3, 2), v); check(v === 8'hB2, "R7 loaded byte 2", v, 8'hB2);
    rd(mk(3, 3), v); check(v === 8'h13, "R7 unloaded byte 3 kept", v, 8'h13);
  endtask

  task automatic t_edges();
    logic [7:0] v;
    addr = mk(4, 10); din = 8'h11;
    cyc(1); ce_n = 0; we_n = 0; cyc(10);
    addr = mk(4, 20); din = 8'hA5;
    cyc(6); ce_n = 1; we_n = 1; cyc(10);
    wait_idle();
    rd(mk(4, 10), v); check(v === 8'hA5, "R4 offset at start, data at end", v, 8'hA5);
    rd(mk(4, 20), v); check(v !== 8'hA5, "R4 late offset unused", v, 8'hA5);
  endtask

  task automatic t_page_freeze();
    logic [7:0] v;
    strobe(mk(5, 0), 8'h50, 0);
    strobe(mk(6, 1), 8'h51, 0);
    wait_idle();
    rd(mk(5, 1), v); check(v === 8'h51, "R5 second byte in frozen page", v, 8'h51);
    rd(mk(6, 1), v); check(v !== 8'h51, "R5 other page untouched", v, 8'h51);
  endtask

  task automatic t_window();
    logic [7:0] v;
    strobe(mk(7, 0), 8'h31, 0);
    cyc(WIN);
    strobe(mk(7, 1), 8'h32, 0);
    wait_idle();
    rd(mk(7, 0), v); check(v === 8'h31, "R6 early byte programmed", v, 8'h31);
    rd(mk(7, 1), v); check(v !== 8'h32, "R6 late byte ignored", v, 8'h32);
  endtask

  task automatic t_oe_low();
    logic [7:0] v;
    strobe(mk(14, 0), 8'h66, 1);
    cyc(30);
    check(busy === 1'b0, "R2 no busy with oe_n low", {7'd0, busy}, 8'd0);
    cyc(IDLE + PROG + 80);
    rd(mk(14, 0), v); check(v !== 8'h66, "R2 nothing stored with oe_n low", v, 8'h66);
  endtask

  task automatic t_glitch();
    logic [7:0] v;
    addr = mk(13, 0); din = 8'h99;
    cyc(1); ce_n = 0; we_n = 0; cyc(FILT - 1); ce_n = 1; we_n = 1;
    cyc(30);
    check(busy === 1'b0, "R3 glitch starts no write", {7'd0, busy}, 8'd0);
    cyc(IDLE + PROG + 80);
    rd(mk(13, 0), v); check(v !== 8'h99, "R3 glitch stores nothing", v, 8'h99);
  endtask

  task automatic t_during_prog();
    logic [7:0] v;
    strobe(mk(10, 0), 8'h41, 0);
    cyc(IDLE + 30);
    strobe(mk(10, 1), 8'h42, 0);
    strobe(mk(11, 1), 8'h43, 0);
    wait_idle();
    cyc(40);
    check(busy === 1'b0, "R9 no new cycle from ignored strobes", {7'd0, busy}, 8'd0);
    rd(mk(10, 0), v); check(v === 8'h41, "R9 original byte committed", v, 8'h41);
    rd(mk(10, 1), v); check(v !== 8'h42, "R9 strobe during program ignored", v, 8'h42);
    rd(mk(11, 1), v); check(v !== 8'h43, "R9 other page ignored", v, 8'h43);
  endtask

  task automatic t_abort();
    logic [7:0] v;
    strobe(mk(9, 0), 8'h77, 0);
    cyc(IDLE + 30);
    check(busy === 1'b1, "R10 busy before abort", {7'd0, busy}, 8'd1);
    res_n = 1'b0;
    cyc(12);
    check(busy === 1'b0, "R10 abort drops busy", {7'd0, busy}, 8'd0);
    strobe(mk(9, 1), 8'h78, 0);
    cyc(10);
    check(busy === 1'b0, "R10 strobe blocked while res_n low", {7'd0, busy}, 8'd0);
    res_n = 1'b1;
    cyc(IDLE + PROG + 80);
    check(busy === 1'b0, "R10 nothing resumes after release", {7'd0, busy}, 8'd0);
    rd(mk(9, 0), v); check(v !== 8'h77, "R10 aborted page unchanged", v, 8'h77);
    rd(mk(9, 1), v); check(v !== 8'h78, "R10 blocked byte not stored", v, 8'h78);
  endtask

  task automatic t_full_page();
    logic [7:0] v;
    int bad = 0;
    for (int k = 0; k < 64; k++) strobe(mk(12, k), 8'(k) ^ 8'h5A, 0);
    wait_idle();
    for (int k = 0; k < 64; k++) begin
      rd(mk(12, k), v);
      if (v !== (8'(k) ^ 8'h5A)) bad++;
    end
    check(bad == 0, "R11 full 64-byte page", 8'(bad), 8'd0);
  endtask

  initial begin
    cyc(4);
    rst = 1'b0;
    cyc(4);
    t_reset();
    t_basic();
    t_partial();
    t_edges();
    t_page_freeze();
    t_window();
    t_oe_low();
    t_glitch();
    t_during_prog();
    t_abort();
    t_full_page();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule